// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a set of level-sensitive interrupt lines and routes them to a small group of CPUs. Each line has one mask bit, one software-trigger bit and an affinity vector naming the CPUs it may reach. Each CPU also owns two inter-processor interrupts (IPIs). A line requests service while its input or its software-trigger bit is high, it is unmasked, and the target CPU is in its affinity.

Each CPU reads a single event register. The read returns the highest-priority source: the lowest-numbered line first, then IPI 0, then IPI 1. The same read acknowledges that source by masking it, so software must unmask it before the source can be delivered again. Registers are reached through a simple word-addressed read/write port. A shared window resolves to the CPU named by the requester-ID input, and one explicit window per CPU reaches any CPU directly.

Top module: `evtirq_ctrl`

## Requirements
- R1: After reset every line is masked, every software trigger is clear, every line's affinity selects all CPUs, every IPI is clear and masked, `bus_rdata` is zero and `cpu_irq` is zero.
- R2: Line i requests CPU c exactly when (hw_irq[i] OR its software trigger) is high, its mask bit is 0 and affinity bit c is 1. Masked lines are never delivered.
- R3: Writing 1s to word address 0x010+k clears, and to 0x000+k sets, the mask bits of lines 32k..32k+31 (bit b is line 32k+b). Bits written as 0 are untouched. Reading either address returns the mask word.
- R4: Addresses 0x020+k and 0x030+k set and clear software-trigger bits in the same bitwise way and read back the trigger word. 0x040+k reads the raw request (input OR trigger). A software trigger alone raises a line.
- R5: Address 0x100+i holds line i's affinity, with bit c meaning CPU c. Reads of lines at or above the line count return 0.
- R6: The event register (CPU register 0) reads {14'b0, kind[1:0], num[15:0]}, with kind 0 meaning none, 1 a line and 2 an IPI. The lowest-numbered requesting line wins, and the register reads 0 when nothing is pending.
- R7: A read that delivers a line sets that line's mask bit at the same clock edge.
- R8: CPU window c starts at 0x200+8c. Offset +1 raises IPIs (bit j is IPI j), +2 clears pending, +3 unmasks and +4 masks. Reads at +1/+2 return the pending bits and at +3/+4 the mask bits.
- R9: IPIs rank below every line, and IPI 0 ranks above IPI 1. Delivering an IPI clears its pending bit and sets its mask bit.
- R10: The shared window 0x300+r acts on CPU `req_cpu`. If `req_cpu` names no CPU, writes there are ignored and reads return 0.
- R11: `cpu_irq[c]` is high exactly when CPU c's event register would read non-zero. It follows state and inputs without a clock.
- R12: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`, and holds while no read is made. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cpu | input | CPU_W | CPU issuing the current access, used by the shared window |
| bus_addr | input | 12 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (event reads acknowledge) |
| bus_rdata | output | 32 | Registered read data |
| hw_irq | input | NUM_LINES | Level-sensitive interrupt lines |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The bench builds the controller with 40 lines and 3 CPUs. The second mask and trigger words are therefore only partly populated, and reads above the last line must return zero bits. With three CPUs the 2-bit requester ID can name a CPU that does not exist, which exercises the shared-window ignore rule. Affinity values restricted to a single CPU show that an acknowledgement by one CPU masks the line for every CPU.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_HW = 2'd1, EV_IPI = 2'd2} ev_kind_e;

  // region code in addr[11:8]
  localparam logic [3:0] RG_LINES = 4'h0;
  localparam logic [3:0] RG_AFF   = 4'h1;
  localparam logic [3:0] RG_CPU   = 4'h2;
  localparam logic [3:0] RG_LOCAL = 4'h3;

  // line group in addr[7:4]
  localparam logic [3:0] GP_MSET = 4'd0;
  localparam logic [3:0] GP_MCLR = 4'd1;
  localparam logic [3:0] GP_SSET = 4'd2;
  localparam logic [3:0] GP_SCLR = 4'd3;
  localparam logic [3:0] GP_RAW  = 4'd4;

  // per-CPU register in addr[2:0]
  localparam logic [2:0] CS_EVENT  = 3'd0;
  localparam logic [2:0] CS_RAISE  = 3'd1;
  localparam logic [2:0] CS_PCLR   = 3'd2;
  localparam logic [2:0] CS_UNMASK = 3'd3;
  localparam logic [2:0] CS_MASK   = 3'd4;

  function automatic logic [DATA_W-1:0] ev_word(ev_kind_e k, logic [15:0] n);
    return {14'd0, k, n};
  endfunction
endpackage

// File: rtl/evtirq_pick.sv
module evtirq_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/evtirq_lines.sv
module evtirq_lines
  import evtirq_pkg::*;
#(
  parameter int N = 64,
  parameter int C = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N-1:0]        hw,
  input  logic [N-1:0]        ack,
  output logic [C-1:0][N-1:0] req,
  output logic [DATA_W-1:0]   rd_word
);
  localparam int NW = (N + 31) / 32;

  logic [N-1:0] mask_q, sw_q;
  logic [C-1:0] aff_q [N];

  logic [3:0] rg, grp, word;
  logic [7:0] line;
  logic       in_lines, in_aff, line_ok;

  assign rg       = addr[11:8];
  assign grp      = addr[7:4];
  assign word     = addr[3:0];
  assign line     = addr[7:0];
  assign in_lines = (rg == RG_LINES) && (int'(word) < NW);
  assign in_aff   = (rg == RG_AFF);
  assign line_ok  = int'(line) < N;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sw_q   <= '0;
      for (int i = 0; i < N; i++) aff_q[i] <= '1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr && in_lines && int'(word) == i / 32) begin
          if (grp == GP_MCLR && wdata[5'(i % 32)]) mask_q[i] <= 1'b0;
          if (grp == GP_MSET && wdata[5'(i % 32)]) mask_q[i] <= 1'b1;
          if (grp == GP_SCLR && wdata[5'(i % 32)]) sw_q[i]   <= 1'b0;
          if (grp == GP_SSET && wdata[5'(i % 32)]) sw_q[i]   <= 1'b1;
        end
        if (ack[i]) mask_q[i] <= 1'b1;
      end
      if (wr && in_aff && line_ok) aff_q[line] <= wdata[C-1:0];
    end
  end

  always_comb begin
    for (int c = 0; c < C; c++)
      for (int i = 0; i < N; i++)
        req[c][i] = (hw[i] | sw_q[i]) & ~mask_q[i] & aff_q[i][c];
  end

  always_comb begin
    rd_word = '0;
    if (in_lines) begin
      for (int b = 0; b < 32; b++) begin
        if (int'(word) * 32 + b < N) begin
          case (grp)
            GP_MSET, GP_MCLR: rd_word[b] = mask_q[int'(word) * 32 + b];
            GP_SSET, GP_SCLR: rd_word[b] = sw_q[int'(word) * 32 + b];
            GP_RAW:           rd_word[b] = hw[int'(word) * 32 + b] | sw_q[int'(word) * 32 + b];
            default:          rd_word[b] = 1'b0;
          endcase
        end
      end
    end else if (in_aff && line_ok) begin
      rd_word = DATA_W'(aff_q[line]);
    end
  end
endmodule

// File: rtl/evtirq_cpu.sv
module evtirq_cpu
  import evtirq_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req,
  input  logic              wr,
  input  logic [2:0]        sel,
  input  logic [1:0]        wbits,
  input  logic              ev_rd,
  output logic [DATA_W-1:0] evt,
  output logic              irq,
  output logic [N-1:0]      ack_vec,
  output logic [1:0]        ipend,
  output logic [1:0]        imask
);
  logic          found;
  logic [IW-1:0] idx;
  logic [1:0]    ipi_eff;

  evtirq_pick #(.N(N), .IW(IW)) u_pick (.req(req), .found(found), .idx(idx));

  assign ipi_eff = ipend & ~imask;
  assign irq     = found | (|ipi_eff);
  assign ack_vec = (ev_rd && found) ? (N'(1) << idx) : '0;

  always_comb begin
    if (found)           evt = ev_word(EV_HW, 16'(idx));
    else if (ipi_eff[0]) evt = ev_word(EV_IPI, 16'd0);
    else if (ipi_eff[1]) evt = ev_word(EV_IPI, 16'd1);
    else                 evt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipend <= '0;
      imask <= '1;
    end else begin
      if (wr) begin
        case (sel)
          CS_RAISE:  ipend <= ipend | wbits;
          CS_PCLR:   ipend <= ipend & ~wbits;
          CS_UNMASK: imask <= imask & ~wbits;
          CS_MASK:   imask <= imask | wbits;
          default:   ;
        endcase
      end
      if (ev_rd && !found) begin
        if (ipi_eff[0]) begin
          ipend[0] <= 1'b0;
          imask[0] <= 1'b1;
        end else if (ipi_eff[1]) begin
          ipend[1] <= 1'b0;
          imask[1] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CPU_W-1:0]     req_cpu,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] hw_irq,
  output logic [NUM_CPUS-1:0]  cpu_irq
);
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] req_a, ack_a;
  logic [NUM_CPUS-1:0][DATA_W-1:0]    evt_a;
  logic [NUM_CPUS-1:0][1:0]           ipend_a, imask_a;
  logic [NUM_CPUS-1:0]                ev_rd_a;
  logic [NUM_LINES-1:0]               ack_or;
  logic [DATA_W-1:0]                  line_word, cpu_word;
  logic [3:0]                         rg;
  logic [4:0]                         tgt;
  logic [2:0]                         sel;
  logic                               cpu_hit;

  assign rg      = bus_addr[11:8];
  assign sel     = bus_addr[2:0];
  assign tgt     = (rg == RG_LOCAL) ? 5'(req_cpu) : bus_addr[7:3];
  assign cpu_hit = ((rg == RG_CPU) || (rg == RG_LOCAL)) && (int'(tgt) < NUM_CPUS);

  evtirq_lines #(.N(NUM_LINES), .C(NUM_CPUS)) u_lines (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hw(hw_irq), .ack(ack_or), .req(req_a), .rd_word(line_word)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign ev_rd_a[c] = bus_rd && cpu_hit && (tgt == 5'(c)) && (sel == CS_EVENT);
    evtirq_cpu #(.N(NUM_LINES), .IW(LINE_W)) u_cpu (
      .clk(clk), .rst(rst), .req(req_a[c]),
      .wr(bus_wr && cpu_hit && (tgt == 5'(c))), .sel(sel), .wbits(bus_wdata[1:0]),
      .ev_rd(ev_rd_a[c]), .evt(evt_a[c]), .irq(cpu_irq[c]), .ack_vec(ack_a[c]),
      .ipend(ipend_a[c]), .imask(imask_a[c])
    );
  end

  always_comb begin
    ack_or   = '0;
    cpu_word = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      ack_or = ack_or | ack_a[c];
      if (tgt == 5'(c)) begin
        case (sel)
          CS_EVENT:            cpu_word = evt_a[c];
          CS_RAISE, CS_PCLR:   cpu_word = DATA_W'(ipend_a[c]);
          CS_UNMASK, CS_MASK:  cpu_word = DATA_W'(imask_a[c]);
          default:             cpu_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= cpu_hit ? cpu_word : line_word;
  end
endmodule

// File: rtl/evtirq_chk.sv
module evtirq_chk #(
  parameter int N = 64,
  parameter int C = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic [C-1:0]  cpu_irq,
  input logic [C-1:0]  ev_rd,
  input logic [N-1:0]  ack,
  input logic [N-1:0]  mask
);
  logic ev_hit, irq_at;
  assign ev_hit = |ev_rd;
  assign irq_at = |(ev_rd & cpu_irq);

  // R7
  mask_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack) |=> ((mask & $past(ack)) == $past(ack)));

  // R2
  no_masked_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> ((ack & mask) == '0));

  // R6
  one_ack_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ack));

  // R11
  evt_vs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ev_hit |=> ((bus_rdata != 32'd0) == $past(irq_at)));

  // R6
  evt_kind_chk: assert property (@(posedge clk) disable iff (rst)
    ev_hit |=> (bus_rdata[31:18] == 14'd0 && bus_rdata[17:16] != 2'b11));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind evtirq_ctrl evtirq_chk #(.N(NUM_LINES), .C(NUM_CPUS)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
  .ev_rd(ev_rd_a), .ack(ack_or), .mask(u_lines.mask_q)
);

// File: tb/sim_evtirq_ctrl.sv
`timescale 1ns/1ps
module sim_evtirq_ctrl;
  localparam int NL = 40;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rq = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd_en = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [NL-1:0] hw = '0;
  logic [NC-1:0] irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evtirq_ctrl #(.NUM_LINES(NL), .NUM_CPUS(NC)) u0 (
    .clk(clk), .rst(rst), .req_cpu(rq), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wd), .bus_rd(rd_en), .bus_rdata(rdata), .hw_irq(hw), .cpu_irq(irq)
  );

  // behavioural reference state
  bit m_mask[NL];
  bit m_sw[NL];
  int m_aff[NL];
  bit m_ip[NC][2];
  bit m_im[NC][2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int win_line(int c);
    for (int i = 0; i < NL; i++)
      if ((hw[i] || m_sw[i]) && !m_mask[i] && ((m_aff[i] >> c) & 1) == 1) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_evt(int c);
    int l = win_line(c);
    if (l >= 0) return 32'h10000 | 32'(l);
    if (m_ip[c][0] && !m_im[c][0]) return 32'h20000;
    if (m_ip[c][1] && !m_im[c][1]) return 32'h20001;
    return 32'h0;
  endfunction

  function automatic int cpu_of(logic [11:0] a, int r);
    int c = -1;
    if (a[11:8] == 4'h2) c = int'(a[7:3]);
    else if (a[11:8] == 4'h3) c = r;
    if (c >= NC) c = -1;
    return c;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a, int r);
    logic [31:0] v = '0;
    int c = cpu_of(a, r);
    if (a[11:8] == 4'h0) begin
      for (int b = 0; b < 32; b++) begin
        int ix = int'(a[3:0]) * 32 + b;
        if (ix < NL) begin
          if (a[7:4] <= 4'd1) v[b] = m_mask[ix];
          else if (a[7:4] <= 4'd3) v[b] = m_sw[ix];
          else if (a[7:4] == 4'd4) v[b] = hw[ix] | m_sw[ix];
        end
      end
    end else if (a[11:8] == 4'h1) begin
      if (int'(a[7:0]) < NL) v = 32'(m_aff[a[7:0]]);
    end else if (c >= 0) begin
      case (a[2:0])
        3'd0: v = model_evt(c);
        3'd1, 3'd2: v = {30'd0, m_ip[c][1], m_ip[c][0]};
        3'd3, 3'd4: v = {30'd0, m_im[c][1], m_im[c][0]};
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic model_ack(int c);
    int l = win_line(c);
    if (l >= 0) m_mask[l] = 1'b1;
    else if (m_ip[c][0] && !m_im[c][0]) begin m_ip[c][0] = 1'b0; m_im[c][0] = 1'b1; end
    else if (m_ip[c][1] && !m_im[c][1]) begin m_ip[c][1] = 1'b0; m_im[c][1] = 1'b1; end
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d, int r);
    int c = cpu_of(a, r);
    if (a[11:8] == 4'h0) begin
      for (int b = 0; b < 32; b++) begin
        int ix = int'(a[3:0]) * 32 + b;
        if (ix < NL && d[b]) begin
          case (a[7:4])
            4'd0: m_mask[ix] = 1'b1;
            4'd1: m_mask[ix] = 1'b0;
            4'd2: m_sw[ix] = 1'b1;
            4'd3: m_sw[ix] = 1'b0;
            default: ;
          endcase
        end
      end
    end else if (a[11:8] == 4'h1) begin
      if (int'(a[7:0]) < NL) m_aff[a[7:0]] = int'(d[NC-1:0]);
    end else if (c >= 0) begin
      for (int j = 0; j < 2; j++) begin
        if (d[j]) begin
          case (a[2:0])
            3'd1: m_ip[c][j] = 1'b1;
            3'd2: m_ip[c][j] = 1'b0;
            3'd3: m_im[c][j] = 1'b0;
            3'd4: m_im[c][j] = 1'b1;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin m_mask[i] = 1'b1; m_sw[i] = 1'b0; m_aff[i] = (1 << NC) - 1; end
    for (int c = 0; c < NC; c++) for (int j = 0; j < 2; j++) begin m_ip[c][j] = 1'b0; m_im[c][j] = 1'b1; end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d, int r = 0);
    @(posedge clk); #1;
    addr = a; wd = d; wr = 1'b1; rq = 2'(r);
    @(posedge clk); #1;
    wr = 1'b0;
    model_write(a, d, r);
  endtask

  task automatic bus_read(logic [11:0] a, string tag, output logic [31:0] got, input int r = 0);
    logic [31:0] exp;
    int c;
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1; rq = 2'(r);
    exp = model_read(a, r);
    c = cpu_of(a, r);
    @(posedge clk); #1;
    rd_en = 1'b0;
    if (c >= 0 && a[2:0] == 3'd0) model_ack(c);
    got = rdata;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic set_hw(int i, bit v);
    @(posedge clk); #1;
    hw[i] = v;
  endtask

  // R11: every clock, request outputs follow the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NC; c++)
        chk(irq[c] == (model_evt(c) != 0), "R11 cpu_irq", 32'(irq[c]), 32'(model_evt(c) != 0));
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rdata == 0, "R1 rdata", rdata, 0);
    chk(irq == 0, "R1 cpu_irq", 32'(irq), 0);
    bus_read(12'h000, "R1 mask w0", g); chk(g == 32'hFFFFFFFF, "R1 mask w0 lit", g, 32'hFFFFFFFF);
    bus_read(12'h011, "R3 mask w1", g); chk(g == 32'h000000FF, "R3 mask w1 partial", g, 32'hFF);
    bus_read(12'h127, "R5 aff 39", g); chk(g == 32'h7, "R1 aff reset", g, 7);
    bus_read(12'h130, "R5 aff oob", g); chk(g == 0, "R5 aff beyond lines", g, 0);
    bus_read(12'h213, "R1 ipi mask", g); chk(g == 32'h3, "R1 ipi mask lit", g, 3);

    // R2/R3 level lines, bitwise unmask
    set_hw(5, 1); set_hw(3, 1); set_hw(33, 1);
    bus_write(12'h010, 32'h28);
    bus_read(12'h000, "R3 mask after clr", g); chk(g == 32'hFFFFFFD7, "R3 only bits 3,5", g, 32'hFFFFFFD7);
    @(negedge clk); chk(irq == 3'b111, "R2 all cpus", 32'(irq), 7);
    bus_write(12'h103, 32'h2);
    bus_read(12'h200, "R6 cpu0 evt", g); chk(g == 32'h10005, "R6 line5 to cpu0", g, 32'h10005);
    bus_read(12'h000, "R7 mask auto", g); chk(g[5] == 1'b1, "R7 line5 masked", 32'(g[5]), 1);
    bus_read(12'h208, "R6 cpu1 evt", g); chk(g == 32'h10003, "R6 line3 to cpu1", g, 32'h10003);
    bus_read(12'h208, "R6 empty", g); chk(g == 0, "R6 none pending", g, 0);

    // R4 software triggers, R10 shared view
    bus_write(12'h021, 32'h10);
    bus_write(12'h011, 32'h12);
    bus_read(12'h041, "R4 raw", g); chk(g == 32'h12, "R4 raw or", g, 32'h12);
    bus_read(12'h300, "R10 local evt", g, 2); chk(g == 32'h10021, "R10 line33 cpu2", g, 32'h10021);
    bus_read(12'h300, "R4 sw evt", g, 2); chk(g == 32'h10024, "R4 line36 by trigger", g, 32'h10024);
    bus_write(12'h031, 32'h10);
    bus_write(12'h011, 32'h10);
    bus_read(12'h021, "R4 sw cleared", g); chk(g == 0, "R4 trigger clear", g, 0);
    @(negedge clk); chk(irq == 0, "R2 nothing left", 32'(irq), 0);

    // R8/R9 IPIs
    bus_write(12'h209, 32'h3);
    bus_read(12'h209, "R8 pend", g); chk(g == 32'h3, "R8 raised", g, 3);
    @(negedge clk); chk(irq[1] == 1'b0, "R8 masked ipi silent", 32'(irq[1]), 0);
    bus_write(12'h20B, 32'h3);
    bus_write(12'h010, 32'h8);
    bus_read(12'h208, "R9 hw first", g); chk(g == 32'h10003, "R9 line beats ipi", g, 32'h10003);
    bus_read(12'h208, "R9 ipi0", g); chk(g == 32'h20000, "R9 ipi0 first", g, 32'h20000);
    bus_read(12'h20C, "R9 ipi mask", g); chk(g == 32'h1, "R9 ipi0 masked", g, 1);
    bus_read(12'h208, "R9 ipi1", g); chk(g == 32'h20001, "R9 ipi1", g, 32'h20001);
    bus_read(12'h208, "R9 empty", g); chk(g == 0, "R9 drained", g, 0);
    bus_write(12'h20B, 32'h1);
    bus_write(12'h214, 32'h2);

    // R10 shared window on CPU0, then on a CPU that does not exist
    bus_write(12'h301, 32'h1, 0);
    bus_write(12'h302, 32'h1, 0);
    bus_read(12'h301, "R10 pclr", g, 0); chk(g == 0, "R10 clear via shared", g, 0);
    bus_write(12'h301, 32'h1, 0);
    bus_write(12'h303, 32'h1, 0);
    @(negedge clk); chk(irq[0] == 1'b1, "R10 cpu0 ipi", 32'(irq[0]), 1);
    bus_write(12'h301, 32'h2, 3);
    bus_read(12'h301, "R10 bad cpu read", g, 3); chk(g == 0, "R10 bad cpu zero", g, 0);
    bus_read(12'h201, "R10 cpu0 intact", g); chk(g == 32'h1, "R10 cpu0 unchanged", g, 1);
    bus_read(12'h209, "R10 cpu1 intact", g); chk(g == 0, "R10 cpu1 unchanged", g, 0);
    bus_read(12'h211, "R10 cpu2 intact", g); chk(g == 0, "R10 cpu2 unchanged", g, 0);
    bus_read(12'h300, "R10 bad cpu evt", g, 3);
    bus_read(12'h200, "R10 cpu0 ipi still", g); chk(g == 32'h20000, "R10 no ack by bad cpu", g, 32'h20000);

    // R12 unmapped and hold
    bus_read(12'h0F0, "R12 unmapped", g); chk(g == 0, "R12 zero", g, 0);
    bus_read(12'h011, "R12 data", g);
    repeat (3) @(posedge clk);
    #1 chk(rdata == g, "R12 hold", rdata, g);

    // level drop: line deasserted stops requesting
    bus_write(12'h010, 32'h20);
    set_hw(5, 0);
    repeat (3) @(posedge clk);
    set_hw(5, 1);
    bus_read(12'h200, "R2 relevel", g); chk(g == 32'h10005, "R2 line5 again", g, 32'h10005);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule